// File: doc/BRIEF.md
# Key-Tuned Multi-Waveform Sample Generator

This block produces four periodic 8-bit sample streams in parallel: a square wave, a triangle wave, a sawtooth and a 64-point cosine-shaped wave. Each stream is meant to feed one DAC channel. All four streams step together on one shared sample strobe. That strobe comes from a clock divider whose ratio the user sets with two push buttons, one for up and one for down. The current divider setting is output so that a numeric display can show it.

Each button input passes through a two-stage synchroniser and then a stability filter. A press counts only after the level has held for a programmable number of clocks, and each press counts once. A synchronous active-low clear puts every generator and the divider phase back to their start state. The clear keeps the chosen rate. The asynchronous active-low reset returns everything, including the rate, to its initial value.

Top module: `wavegen_top`

## Requirements
- R1: When rstN is low, squareOut=0, triOut=0, sawOut=0, sineOut=255 and rateOut=RESET_RATE (default 0).
- R2: With rate setting N held, the generators advance once every N+1 clocks. After clrN returns high, the first advance happens on the (N+1)-th rising edge. Between advances all outputs are held.
- R3: squareOut is only ever 0 or 255. It starts at 0 and inverts after every 32 advances, so after t advances it is 255 exactly when floor(t/32) is odd.
- R4: triOut starts at 0 and rises by 8 per advance. When it rises from 248 it goes to 255 and the direction turns to falling. It then falls by 8 per advance. When it falls from 7 it goes to 0 and the direction turns to rising. One full cycle is 64 advances.
- R5: sawOut adds SAW_STEP (default 16) modulo 256 on every advance, starting from 0.
- R6: After t advances, sineOut equals floor(127.5 + 127.5·cos(2π·(t mod 64)/63)). This gives 255 at indices 0 and 63, and 0 at indices 31 and 32.
- R7: Each accepted up press adds 1 to rateOut. At 255 the value stays at 255.
- R8: Each accepted down press subtracts 1 from rateOut. At 0 the value stays at 0.
- R9: A button level that holds for fewer than DEB_CYCLES clocks is ignored. A press held for any longer time counts exactly once.
- R10: While clrN is low, the generators return to their R1 values and the divider phase restarts. rateOut is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clrN | input | 1 | Synchronous active-low clear of the generators and divider phase |
| keyUp | input | 1 | Raw up button, high when pressed |
| keyDown | input | 1 | Raw down button, high when pressed |
| squareOut | output | 8 | Square wave sample |
| triOut | output | 8 | Triangle wave sample |
| sawOut | output | 8 | Sawtooth sample |
| sineOut | output | 8 | Cosine-table sample |
| rateOut | output | 8 | Current divider setting N |

## Verification
Every waveform output is registered once past the divider strobe. After clrN is released, the outputs change on clock edges N+1, 2(N+1), and so on. The bench counts rising edges from the release and samples on falling edges. At each falling edge it compares all four outputs against a reference indexed by floor(edges/(N+1)). A button press takes two synchroniser stages plus DEB_CYCLES clocks before rateOut moves. The bench therefore holds each key level for DEB_CYCLES+6 clocks before releasing it, and reads rateOut only after the release has settled.

// File: rtl/wavegen_pkg.sv
package wavegen_pkg;
  // Strobes handed from the control side to the sample datapath.
  typedef struct packed {
    logic tick;   // advance every generator by one step
    logic clear;  // return generators to their start state
  } strobeT;
endpackage

// File: rtl/key_filter.sv
module key_filter #(
  parameter int DEB_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawKey,
  output logic press
);
  localparam int CW = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;

  logic [1:0]    syncQ;
  logic          stable;
  logic [CW-1:0] holdCnt;
  logic          settle;

  assign settle = (syncQ[1] != stable) && (holdCnt == CW'(DEB_CYCLES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      stable  <= 1'b0;
      holdCnt <= '0;
      press   <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], rawKey};
      press <= settle && syncQ[1];
      if (syncQ[1] == stable) begin
        holdCnt <= '0;
      end else if (settle) begin
        stable  <= syncQ[1];
        holdCnt <= '0;
      end else begin
        holdCnt <= holdCnt + 1'b1;
      end
    end
  end

  // R9: an accepted press is a single-cycle event
  p_single_press_r9: assert property (@(posedge clk) disable iff (!rstN)
    press |=> !press);
endmodule

// File: rtl/wave_ctrl.sv
module wave_ctrl
  import wavegen_pkg::*;
#(
  parameter int RATE_W     = 8,
  parameter int RESET_RATE = 0,
  parameter int DEB_CYCLES = 1000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clrN,
  input  logic              keyUp,
  input  logic              keyDown,
  output strobeT            strb,
  output logic [RATE_W-1:0] rateSel
);
  localparam int NUM_KEYS = 2;
  localparam logic [RATE_W-1:0] RATE_MAX = '1;

  logic [NUM_KEYS-1:0] rawKeys;
  logic [NUM_KEYS-1:0] pressEvt;
  logic [RATE_W-1:0]   divCnt;
  logic                upEvt, dnEvt;

  assign rawKeys = {keyDown, keyUp};

  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_key
    key_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
      .clk    (clk),
      .rstN   (rstN),
      .rawKey (rawKeys[g]),
      .press  (pressEvt[g])
    );
  end

  assign upEvt = pressEvt[0] && !pressEvt[1];
  assign dnEvt = pressEvt[1] && !pressEvt[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateSel <= RATE_W'(RESET_RATE);
    end else if (upEvt && rateSel != RATE_MAX) begin
      rateSel <= rateSel + 1'b1;
    end else if (dnEvt && rateSel != '0) begin
      rateSel <= rateSel - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  divCnt <= '0;
    else if (!clrN)             divCnt <= '0;
    else if (divCnt >= rateSel) divCnt <= '0;
    else                        divCnt <= divCnt + 1'b1;
  end

  assign strb.tick  = clrN && (divCnt >= rateSel);
  assign strb.clear = !clrN;

  // R7: the setting never wraps past its ceiling
  p_rate_ceiling_r7: assert property (@(posedge clk) disable iff (!rstN)
    (upEvt && rateSel == RATE_MAX) |=> rateSel == RATE_MAX);
  // R8: the setting never wraps below zero
  p_rate_floor_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dnEvt && rateSel == '0) |=> rateSel == '0);
  // R2: the divider restarts its count after each strobe
  p_tick_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.tick |=> divCnt == '0);
  // R10: a clear leaves the rate untouched
  p_clear_keeps_rate_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!clrN && !upEvt && !dnEvt) |=> $stable(rateSel));
endmodule

// File: rtl/wave_datapath.sv
module wave_datapath
  import wavegen_pkg::*;
#(
  parameter int SW       = 8,
  parameter int SAW_STEP = 16,
  parameter int TRI_STEP = 8,
  parameter int SQ_HALF  = 32,
  parameter int SINE_PTS = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeT        strb,
  output logic [SW-1:0] squareOut,
  output logic [SW-1:0] triOut,
  output logic [SW-1:0] sawOut,
  output logic [SW-1:0] sineOut
);
  localparam int            SQ_CW    = (SQ_HALF > 1) ? $clog2(SQ_HALF) : 1;
  localparam int            IDX_W    = $clog2(SINE_PTS);
  localparam logic [SW-1:0] FULL     = '1;
  localparam int            FULL_INT = (1 << SW) - 1;
  localparam real           HALF_AMP = FULL_INT / 2.0;
  localparam real           TWO_PI   = 6.283185307179586;

  logic [SQ_CW-1:0] sqCnt;
  logic             sqLevel;
  logic [SW-1:0]    triVal;
  logic             triUp;
  logic [SW-1:0]    sawVal;
  logic [IDX_W-1:0] sineIdx;
  logic [SW-1:0]    sineRom [SINE_PTS];

  // Cosine table computed at elaboration, symmetric about the middle index.
  for (genvar g = 0; g < SINE_PTS; g++) begin : g_rom
    localparam real PT = HALF_AMP + HALF_AMP * $cos(TWO_PI * g / (SINE_PTS - 1));
    localparam int  PI_ = int'($floor(PT + 1.0e-6));
    assign sineRom[g] = (PI_ > FULL_INT) ? FULL : SW'(PI_);
  end

  // Square: level inverts after SQ_HALF strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sqCnt <= '0; sqLevel <= 1'b0;
    end else if (strb.clear) begin
      sqCnt <= '0; sqLevel <= 1'b0;
    end else if (strb.tick) begin
      if (sqCnt == SQ_CW'(SQ_HALF - 1)) begin
        sqCnt   <= '0;
        sqLevel <= !sqLevel;
      end else begin
        sqCnt <= sqCnt + 1'b1;
      end
    end
  end

  // Triangle: steps with clamping at both ends
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      triVal <= '0; triUp <= 1'b1;
    end else if (strb.clear) begin
      triVal <= '0; triUp <= 1'b1;
    end else if (strb.tick) begin
      if (triUp) begin
        if (triVal > FULL - SW'(TRI_STEP)) begin
          triVal <= FULL; triUp <= 1'b0;
        end else begin
          triVal <= triVal + SW'(TRI_STEP);
        end
      end else begin
        if (triVal < SW'(TRI_STEP)) begin
          triVal <= '0; triUp <= 1'b1;
        end else begin
          triVal <= triVal - SW'(TRI_STEP);
        end
      end
    end
  end

  // Sawtooth and table index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sawVal <= '0; sineIdx <= '0;
    end else if (strb.clear) begin
      sawVal <= '0; sineIdx <= '0;
    end else if (strb.tick) begin
      sawVal  <= sawVal + SW'(SAW_STEP);
      sineIdx <= (sineIdx == IDX_W'(SINE_PTS - 1)) ? '0 : sineIdx + 1'b1;
    end
  end

  assign squareOut = sqLevel ? FULL : '0;
  assign triOut    = triVal;
  assign sawOut    = sawVal;
  assign sineOut   = sineRom[sineIdx];

  // R5: each strobe adds the step modulo the sample range
  p_saw_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.clear) |=> sawVal == SW'($past(sawVal) + SW'(SAW_STEP)));
  // R4: rising from the top step clamps to full scale and turns down
  p_tri_peak_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.clear && triUp && triVal == FULL - SW'(TRI_STEP) + 1'b1)
      |=> (triVal == FULL && !triUp));
  // R2: no strobe, no movement
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tick && !strb.clear) |=>
      ($stable(sawVal) && $stable(triVal) && $stable(sineIdx) && $stable(sqLevel)));
  // R10: clear returns the generators to their start state
  p_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (sawVal == '0 && triVal == '0 && sineIdx == '0 && !sqLevel));
endmodule

// File: rtl/wavegen_top.sv
module wavegen_top
  import wavegen_pkg::*;
#(
  parameter int SW         = 8,
  parameter int RATE_W     = 8,
  parameter int RESET_RATE = 0,
  parameter int DEB_CYCLES = 1000000,
  parameter int SAW_STEP   = 16,
  parameter int TRI_STEP   = 8,
  parameter int SQ_HALF    = 32,
  parameter int SINE_PTS   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clrN,
  input  logic              keyUp,
  input  logic              keyDown,
  output logic [SW-1:0]     squareOut,
  output logic [SW-1:0]     triOut,
  output logic [SW-1:0]     sawOut,
  output logic [SW-1:0]     sineOut,
  output logic [RATE_W-1:0] rateOut
);
  strobeT strb;

  wave_ctrl #(
    .RATE_W(RATE_W), .RESET_RATE(RESET_RATE), .DEB_CYCLES(DEB_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .clrN(clrN), .keyUp(keyUp), .keyDown(keyDown),
    .strb(strb), .rateSel(rateOut)
  );

  wave_datapath #(
    .SW(SW), .SAW_STEP(SAW_STEP), .TRI_STEP(TRI_STEP),
    .SQ_HALF(SQ_HALF), .SINE_PTS(SINE_PTS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .squareOut(squareOut), .triOut(triOut), .sawOut(sawOut), .sineOut(sineOut)
  );
endmodule

// File: tb/wavegen_top_test.sv
`timescale 1ns/1ps
module wavegen_top_test;
  localparam int DEB = 8;
  localparam int STEP = 16;
  localparam int HOLD = DEB + 6;
  localparam real PI2 = 6.283185307179586;
  // stimulus table: up presses, down presses, expected rate afterwards
  localparam int NV = 4;
  localparam int VEC [NV][3] = '{'{3, 0, 3}, '{0, 1, 2}, '{1, 3, 0}, '{0, 2, 0}};

  logic clk = 1'b0;
  logic rstN = 1'b0, clrN = 1'b1, keyUp = 1'b0, keyDown = 1'b0;
  logic [7:0] squareOut, triOut, sawOut, sineOut, rateOut;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  wavegen_top #(.DEB_CYCLES(DEB), .SAW_STEP(STEP)) uut (
    .clk(clk), .rstN(rstN), .clrN(clrN), .keyUp(keyUp), .keyDown(keyDown),
    .squareOut(squareOut), .triOut(triOut), .sawOut(sawOut),
    .sineOut(sineOut), .rateOut(rateOut));

  function automatic int sineRef(int i);
    int v = int'($floor(127.5 + 127.5 * $cos(PI2 * i / 63.0) + 1.0e-6));
    return (v > 255) ? 255 : v;
  endfunction

  function automatic int triRef(int t);
    int p = t % 64;
    return (p <= 31) ? 8 * p : 255 - 8 * (p - 32);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pressKey(bit up, int holdCycles);
    @(negedge clk);
    if (up) keyUp = 1'b1; else keyDown = 1'b1;
    cycles(holdCycles);
    keyUp = 1'b0; keyDown = 1'b0;
    cycles(HOLD);
  endtask

  // Pulse clear, then compare all outputs each cycle against the R2-R6 references
  task automatic runWaves(int n, int ticks);
    int bad = 0;
    @(negedge clk); clrN = 1'b0;
    @(negedge clk); clrN = 1'b1;
    for (int c = 1; c <= ticks * (n + 1); c++) begin
      int t;
      @(negedge clk);
      t = c / (n + 1);
      if (squareOut != (((t / 32) % 2 == 1) ? 8'd255 : 8'd0)) begin
        bad++; check("R3 square", squareOut, ((t / 32) % 2 == 1) ? 255 : 0);
      end
      if (triOut != 8'(triRef(t))) begin bad++; check("R4 triangle", triOut, triRef(t)); end
      if (sawOut != 8'((t * STEP) % 256)) begin
        bad++; check("R5 sawtooth", sawOut, (t * STEP) % 256);
      end
      if (sineOut != 8'(sineRef(t % 64))) begin
        bad++; check("R6 sine", sineOut, sineRef(t % 64));
      end
      if (bad > 8) break;
    end
    check("R2 waveform timing at rate", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    cycles(3);
    // R1 reset state
    check("R1 square", squareOut, 0);
    check("R1 triangle", triOut, 0);
    check("R1 sawtooth", sawOut, 0);
    check("R1 sine", sineOut, 255);
    check("R1 rate", rateOut, 0);
    @(negedge clk); rstN = 1'b1;
    cycles(2);

    // Stimulus table: key presses then waveform walk at the resulting rate (R7, R8, R2-R6)
    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < VEC[v][0]; k++) pressKey(1'b1, HOLD);
      for (int k = 0; k < VEC[v][1]; k++) pressKey(1'b0, HOLD);
      check("R7/R8 rate after presses", rateOut, VEC[v][2]);
      runWaves(VEC[v][2], 130);
    end

    // R9: short glitch ignored, long hold counts once
    pressKey(1'b1, 3);
    check("R9 glitch ignored", rateOut, 0);
    pressKey(1'b1, 6 * DEB);
    check("R9 long hold counts once", rateOut, 1);

    // R10: clear mid-run restarts generators and keeps rate
    runWaves(1, 40);
    @(negedge clk); clrN = 1'b0;
    @(negedge clk);
    check("R10 saw cleared", sawOut, 0);
    check("R10 tri cleared", triOut, 0);
    check("R10 sine restart", sineOut, 255);
    check("R10 rate kept", rateOut, 1);
    clrN = 1'b1;
    cycles(2);

    // R7 ceiling saturation, then R8 step down from the top
    for (int k = 0; k < 258; k++) pressKey(1'b1, HOLD);
    check("R7 ceiling", rateOut, 255);
    pressKey(1'b0, HOLD);
    check("R8 decrement", rateOut, 254);
    runWaves(254, 2);

    // R1 asynchronous reset restores everything including rate
    @(negedge clk); rstN = 1'b0;
    #1;
    check("R1 rate after reset", rateOut, 0);
    check("R1 saw after reset", sawOut, 0);
    check("R1 sine after reset", sineOut, 255);
    finishRun();
  end
endmodule